// File: doc/BRIEF.md
# Dual Lookup-Table Addressing Datapath

This block drives two DAC code outputs, each from its own 64-row lookup table of 8-bit entries. Every channel has two bypass controls. The first picks the table row. By default the row comes from the upper six bits of an 8-bit converter sample, and a second option takes it from a 6-bit direct row field. The second control picks what reaches the DAC. By default that is the addressed table row, and the other option is a per-channel override code. The two channels share only the converter sample and the table write port. All of their other controls are separate.

The table storage has a simple write port. It is used to load table contents before operation and to change them during operation. Each DAC code is held in a register. The output therefore reflects, one clock later, the inputs and table contents present at a rising edge. Power-on behaviour comes from a synchronous active-high reset, which clears both DAC codes. Table contents are not reset.

Top module: `dual_lut_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, both `dac0_code` and `dac1_code` read 0x00 after that edge.
- R2: With a channel's row select at 0, the row read is `sample[7:2]`. Sample 0x00 addresses row 0 and sample 0xFF addresses row 63.
- R3: With a channel's row select at 1, the row read is that channel's 6-bit direct row field, and `sample` has no effect on that channel.
- R4: With a channel's output select at 1, that channel's DAC code becomes its override code after the next edge, whatever the table holds. With the output select at 0, the DAC code is the addressed table row.
- R5: `wr_table` = 0 writes the table of channel 0, and `wr_table` = 1 writes the table of channel 1. A write to one table never changes the other channel's output.
- R6: The DAC code is registered. An input change made between edges does not appear on the output until the next rising edge, and with stable inputs and no writes the output holds.
- R7: A write with `wr_en` = 1 takes effect at the rising edge. A read of the same row at that same edge returns the old content, and the new content is returned from the following edge on.
- R8: The two least significant bits of `sample` never affect either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sample | input | 8 | Converter code, 0x00 at minimum and 0xFF at full scale |
| ch0_row_sel | input | 1 | Channel 0 row source: 0 sample, 1 direct field |
| ch0_direct_row | input | 6 | Channel 0 direct row index |
| ch0_out_sel | input | 1 | Channel 0 output source: 0 table, 1 override |
| ch0_override | input | 8 | Channel 0 override code |
| ch1_row_sel | input | 1 | Channel 1 row source: 0 sample, 1 direct field |
| ch1_direct_row | input | 6 | Channel 1 direct row index |
| ch1_out_sel | input | 1 | Channel 1 output source: 0 table, 1 override |
| ch1_override | input | 8 | Channel 1 override code |
| wr_en | input | 1 | Table write strobe |
| wr_table | input | 1 | Table chosen for the write (0 or 1) |
| wr_row | input | 6 | Row written |
| wr_data | input | 8 | Data written |
| dac0_code | output | 8 | Registered DAC code of channel 0 |
| dac1_code | output | 8 | Registered DAC code of channel 1 |

## Verification
A corrupted table entry stays hidden until that row is addressed. The bench therefore keeps a shadow of both tables and sweeps rows through both the sample path and the direct path, including the end rows 0 and 63. When a row is addressed, a wrong row index, a misrouted write or a swapped channel shows on the DAC code exactly one edge after the inputs that selected it. A bad output register shows at that same edge, either as a change that appears too early or as a value that is not held.

// File: rtl/dual_lut_pkg.sv
package dual_lut_pkg;
    localparam int SAMPLE_W  = 8;
    localparam int CODE_W    = 8;
    localparam int IDX_W     = 6;
    localparam int NUM_CH    = 2;
    localparam int DEPTH     = 1 << IDX_W;
    localparam int TBL_SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [CODE_W-1:0]   code_t;
    typedef logic [IDX_W-1:0]    row_idx_t;

    typedef enum logic {
        ROW_FROM_SAMPLE = 1'b0,
        ROW_FROM_DIRECT = 1'b1
    } row_src_e;

    typedef enum logic {
        OUT_FROM_TABLE  = 1'b0,
        OUT_FROM_FORCED = 1'b1
    } out_src_e;

    typedef struct packed {
        row_src_e row_src;
        row_idx_t direct_row;
        out_src_e out_src;
        code_t    forced_code;
    } chan_cfg_t;

    typedef struct packed {
        logic                 en;
        logic [TBL_SEL_W-1:0] tbl;
        row_idx_t             row;
        code_t                data;
    } tbl_wr_t;

    // Upper bits of the converter sample give the table row.
    function automatic row_idx_t sample_to_row(sample_t s);
        return s[SAMPLE_W-1 -: IDX_W];
    endfunction
endpackage

// File: rtl/lut_row_select.sv
module lut_row_select
    import dual_lut_pkg::*;
(
    input  sample_t   sample,
    input  chan_cfg_t cfg,
    output row_idx_t  row
);
    always_comb begin
        unique case (cfg.row_src)
            ROW_FROM_DIRECT: row = cfg.direct_row;
            default:         row = sample_to_row(sample);
        endcase
    end
endmodule

// File: rtl/lut_bank.sv
module lut_bank #(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_row,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_row,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_row] <= wr_data;
        end
    end

    // Read data is captured by the output stage at the same edge,
    // so a same-row write returns the old content there.
    assign rd_data = mem[rd_row];
endmodule

// File: rtl/dac_out_stage.sv
module dac_out_stage
    import dual_lut_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  out_src_e out_src,
    input  code_t    forced_code,
    input  code_t    table_data,
    output code_t    code
);
    code_t next_code;

    always_comb begin
        unique case (out_src)
            OUT_FROM_FORCED: next_code = forced_code;
            default:         next_code = table_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
        end else begin
            code <= next_code;
        end
    end
endmodule

// File: rtl/dual_lut_datapath.sv
module dual_lut_datapath
    import dual_lut_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SAMPLE_W-1:0]  sample,
    input  logic                 ch0_row_sel,
    input  logic [IDX_W-1:0]     ch0_direct_row,
    input  logic                 ch0_out_sel,
    input  logic [CODE_W-1:0]    ch0_override,
    input  logic                 ch1_row_sel,
    input  logic [IDX_W-1:0]     ch1_direct_row,
    input  logic                 ch1_out_sel,
    input  logic [CODE_W-1:0]    ch1_override,
    input  logic                 wr_en,
    input  logic [TBL_SEL_W-1:0] wr_table,
    input  logic [IDX_W-1:0]     wr_row,
    input  logic [CODE_W-1:0]    wr_data,
    output logic [CODE_W-1:0]    dac0_code,
    output logic [CODE_W-1:0]    dac1_code
);
    chan_cfg_t cfg   [NUM_CH];
    code_t     codes [NUM_CH];
    tbl_wr_t   wr;

    assign cfg[0] = '{row_src: row_src_e'(ch0_row_sel), direct_row: ch0_direct_row,
                      out_src: out_src_e'(ch0_out_sel), forced_code: ch0_override};
    assign cfg[1] = '{row_src: row_src_e'(ch1_row_sel), direct_row: ch1_direct_row,
                      out_src: out_src_e'(ch1_out_sel), forced_code: ch1_override};
    assign wr = '{en: wr_en, tbl: wr_table, row: wr_row, data: wr_data};

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        row_idx_t rd_row;
        code_t    rd_data;
        logic     bank_we;

        assign bank_we = wr.en && (wr.tbl == TBL_SEL_W'(ch));

        lut_row_select u_row (
            .sample (sample),
            .cfg    (cfg[ch]),
            .row    (rd_row)
        );

        lut_bank #(.IDX_W(IDX_W), .DATA_W(CODE_W)) u_bank (
            .clk     (clk),
            .wr_en   (bank_we),
            .wr_row  (wr.row),
            .wr_data (wr.data),
            .rd_row  (rd_row),
            .rd_data (rd_data)
        );

        dac_out_stage u_out (
            .clk         (clk),
            .rst         (rst),
            .out_src     (cfg[ch].out_src),
            .forced_code (cfg[ch].forced_code),
            .table_data  (rd_data),
            .code        (codes[ch])
        );
    end

    assign dac0_code = codes[0];
    assign dac1_code = codes[1];
endmodule

// File: rtl/dual_lut_checker.sv
module dual_lut_checker
    import dual_lut_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [SAMPLE_W-1:0]  sample,
    input logic                 ch0_row_sel,
    input logic [IDX_W-1:0]     ch0_direct_row,
    input logic                 ch0_out_sel,
    input logic [CODE_W-1:0]    ch0_override,
    input logic                 ch1_row_sel,
    input logic [IDX_W-1:0]     ch1_direct_row,
    input logic                 ch1_out_sel,
    input logic [CODE_W-1:0]    ch1_override,
    input logic                 wr_en,
    input logic [TBL_SEL_W-1:0] wr_table,
    input logic [IDX_W-1:0]     wr_row,
    input logic [CODE_W-1:0]    wr_data,
    input logic [CODE_W-1:0]    dac0_code,
    input logic [CODE_W-1:0]    dac1_code
);
    // R1: reset clears both outputs at the next edge
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (dac0_code == '0 && dac1_code == '0));

    // R4: override select forwards the override code
    assert_override_ch0_R4: assert property (@(posedge clk) disable iff (rst)
        ch0_out_sel |=> dac0_code == $past(ch0_override));
    assert_override_ch1_R4: assert property (@(posedge clk) disable iff (rst)
        ch1_out_sel |=> dac1_code == $past(ch1_override));

    // R6 and R8: stable controls, stable upper sample bits and no write hold the output
    assert_hold_ch0_R6_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en) && $stable(sample[SAMPLE_W-1:SAMPLE_W-IDX_W])
         && $stable(ch0_row_sel) && $stable(ch0_direct_row)
         && $stable(ch0_out_sel) && $stable(ch0_override))
        |=> $stable(dac0_code));
    assert_hold_ch1_R6_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en) && $stable(sample[SAMPLE_W-1:SAMPLE_W-IDX_W])
         && $stable(ch1_row_sel) && $stable(ch1_direct_row)
         && $stable(ch1_out_sel) && $stable(ch1_override))
        |=> $stable(dac1_code));
endmodule

bind dual_lut_datapath dual_lut_checker u_chk (.*);

// File: tb/tb_dual_lut_datapath.sv
module tb_dual_lut_datapath;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] sample;
    logic       row_sel [2];
    logic [5:0] direct_row [2];
    logic       out_sel [2];
    logic [7:0] override [2];
    logic       wr_en;
    logic       wr_table;
    logic [5:0] wr_row;
    logic [7:0] wr_data;
    logic [7:0] dac0_code, dac1_code;

    logic [7:0] shadow [2][64];
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dual_lut_datapath dut (
        .clk(clk), .rst(rst), .sample(sample),
        .ch0_row_sel(row_sel[0]), .ch0_direct_row(direct_row[0]),
        .ch0_out_sel(out_sel[0]), .ch0_override(override[0]),
        .ch1_row_sel(row_sel[1]), .ch1_direct_row(direct_row[1]),
        .ch1_out_sel(out_sel[1]), .ch1_override(override[1]),
        .wr_en(wr_en), .wr_table(wr_table), .wr_row(wr_row), .wr_data(wr_data),
        .dac0_code(dac0_code), .dac1_code(dac1_code)
    );

    function automatic logic [7:0] expect_code(int ch);
        logic [5:0] r;
        if (rst) return 8'h00;
        if (out_sel[ch]) return override[ch];
        r = row_sel[ch] ? direct_row[ch] : sample[7:2];
        return shadow[ch][r];
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Inputs are set before the call; one edge is applied and both outputs checked.
    task automatic step(string tag);
        logic [7:0] e0, e1;
        e0 = expect_code(0);
        e1 = expect_code(1);
        @(posedge clk);
        if (wr_en) shadow[wr_table][wr_row] = wr_data;
        @(negedge clk);
        wr_en = 1'b0;
        check({tag, " ch0"}, dac0_code, e0);
        check({tag, " ch1"}, dac1_code, e1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; sample = '0; wr_en = 1'b0; wr_table = 1'b0; wr_row = '0; wr_data = '0;
        for (int c = 0; c < 2; c++) begin
            row_sel[c] = 1'b0; direct_row[c] = '0; out_sel[c] = 1'b0; override[c] = '0;
        end
        @(negedge clk);
        step("R1 reset");
        // Preload both tables while reset holds the outputs at zero.
        for (int t = 0; t < 2; t++) begin
            for (int r = 0; r < 64; r++) begin
                wr_en = 1'b1; wr_table = t[0]; wr_row = r[5:0]; wr_data = 8'($urandom);
                step("R1 preload");
            end
        end
        rst = 1'b0;

        // R2: end rows through the sample path
        sample = 8'h00; step("R2 sample 00 row 0");
        sample = 8'hFF; step("R2 sample FF row 63");
        // R8: low sample bits ignored
        sample = 8'h83; step("R8 sample 83");
        sample = 8'h80; step("R8 sample 80");
        // R3: direct rows, sample moving
        row_sel[0] = 1'b1; direct_row[0] = 6'd63; row_sel[1] = 1'b1; direct_row[1] = 6'd0;
        sample = 8'h44; step("R3 direct");
        sample = 8'hC8; step("R3 direct sample ignored");
        // R4: overrides, one channel at a time
        out_sel[0] = 1'b1; override[0] = 8'h5A; step("R4 override ch0");
        out_sel[1] = 1'b1; override[1] = 8'hA5; out_sel[0] = 1'b0; step("R4 override ch1");
        out_sel[1] = 1'b0;
        // R7: same-row write and read at one edge
        row_sel[0] = 1'b1; direct_row[0] = 6'd17;
        wr_en = 1'b1; wr_table = 1'b0; wr_row = 6'd17; wr_data = ~shadow[0][17];
        begin
            logic [7:0] old_v;
            old_v = shadow[0][17];
            step("R7 same-edge old");
            check("R7 old value", dac0_code, old_v);
        end
        step("R7 new value");
        // R5: write to table 1 at the row channel 0 reads
        row_sel[1] = 1'b1; direct_row[1] = 6'd17;
        wr_en = 1'b1; wr_table = 1'b1; wr_row = 6'd17; wr_data = 8'h3C;
        step("R5 write tbl1");
        step("R5 independence");
        // R6: change input between edges, output must not move before the edge
        begin
            logic [7:0] held;
            held = dac0_code;
            out_sel[0] = 1'b1; override[0] = ~held;
            #1;
            check("R6 no early change", dac0_code, held);
            step("R6 after edge");
        end

        // Random mix
        for (int i = 0; i < 400; i++) begin
            sample = 8'($urandom);
            for (int c = 0; c < 2; c++) begin
                row_sel[c] = 1'($urandom);
                direct_row[c] = 6'($urandom);
                out_sel[c] = ($urandom % 4) == 0;
                override[c] = 8'($urandom);
            end
            wr_en = ($urandom % 3) == 0;
            wr_table = 1'($urandom);
            wr_row = 6'($urandom);
            wr_data = 8'($urandom);
            step("R2 R3 R4 R5 R7 random");
        end

        // R1: reset mid-operation
        rst = 1'b1; out_sel[0] = 1'b1; override[0] = 8'hFF;
        step("R1 reset again");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule